// File: doc/BRIEF.md
# Configurable Logic Macrocell

This block is one output cell of a programmable logic array. It receives two sum-of-products terms (`sop_a`, `sop_b`) from the product-term array. It also receives a bank of block clocks, one per-cell product-term clock, two block-wide initialisation terms and one per-cell initialisation term. From these it produces a pin-bound data bit with its drive enable and an internal feedback bit. A configuration word sets the output path: combinatorial, registered or latched, with optional inversion at the pin. In registered mode the configuration also selects the flop behaviour (D, T, JK or SR), the clock source and the initialisation scheme.

All storage is a single D-type bit. T, JK and SR behaviour are built by XOR-ing the stored bit with a computed toggle term. The block runs on one system clock `clk`. The block clocks and the product-term clock are sampled as levels. The selected source updates the cell on the system-clock cycle in which its active edge is first seen. Initialisation terms are level-sensitive and act on the next system-clock edge. A test preload writes the stored bit directly. A test observe drives the stored bit onto the pin with the drive forced on. The power-up reset (`rst_n`) clears the stored bit, the configuration and the edge history.

Configuration word layout (`cfg_in`, 10 + log2(NCLK) bits):
- bits [1:0] output mode: 0 combinatorial, 1 registered, 2 latched, 3 registered.
- bit 2: pin inversion.
- bits [4:3] flop type: 0 D, 1 T, 2 JK, 3 SR.
- bit 5: asynchronous mode.
- bit 6: use the product-term clock (asynchronous mode only).
- bit 7: product-term clock is active on its falling edge.
- bit 8: swap the roles of the block init terms.
- bit 9: the per-cell init term presets (otherwise it resets).
- bits [10 +: log2(NCLK)]: block clock select.

Top module: `pld_macrocell`

## Requirements
- R1: With output mode 0, `pin_out` equals `sop_a` XOR bit 2 without delay. With modes 1 to 3, `pin_out` equals the stored bit XOR bit 2.
- R2: In registered mode, the value stored on an active clock edge follows the chosen flop type. D stores `sop_a`. T toggles when `sop_a` is 1. JK uses J=`sop_a` and K=`sop_b`, so it toggles when both are 1. SR uses S=`sop_a` and R=`sop_b`, and clears when both are 1.
- R3: In synchronous mode, the cell updates only on a rising edge of `blk_clk[sel]`, where sel is the clock-select field. Edges on the other block clocks leave the stored bit unchanged.
- R4: In asynchronous mode with bit 6 set, the cell is clocked by `pt_clk` instead. The active edge is rising when bit 7 is 0 and falling when bit 7 is 1.
- R5: In synchronous mode with bit 8 clear, `blk_init_a` presets the stored bit to 1 and `blk_init_b` clears it to 0. With bit 8 set, the two roles are exchanged.
- R6: In asynchronous mode, `cell_init` presets the stored bit when bit 9 is 1 and clears it when bit 9 is 0. `blk_init_a` and `blk_init_b` then have no effect.
- R7: When preset and clear are both active, the stored bit becomes 0. Any active init term overrides a preload in the same cycle.
- R8: After `rst_n`, the stored bit and the configuration are 0. In registered mode, the pin then shows the value of bit 2.
- R9: While `preload_en` is 1, the next clock edge stores `preload_val`, regardless of clock source and mode.
- R10: While `observe_en` is 1, `pin_oe` is 1 and `pin_out` equals the stored bit without inversion. Otherwise `pin_oe` equals `oe_term`.
- R11: `fb_out` equals `sop_a` in mode 0 and the stored bit otherwise. It is never inverted and does not depend on `pin_oe`.
- R12: In latched mode, the stored bit takes `sop_a` on each clock edge while the selected source is high. It holds its value while the source is low.
- R13: `cfg_in` is captured only on a clock edge with `cfg_we` at 1. Changes on `cfg_in` at other times have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| cfg_we | input | 1 | Configuration capture enable |
| cfg_in | input | 10+log2(NCLK) | Configuration word |
| sop_a | input | 1 | Primary sum-of-products term (D, T, J or S) |
| sop_b | input | 1 | Secondary sum-of-products term (K or R) |
| blk_clk | input | NCLK | Block clocks, sampled as levels |
| pt_clk | input | 1 | Per-cell product-term clock |
| blk_init_a | input | 1 | Block init term A |
| blk_init_b | input | 1 | Block init term B |
| cell_init | input | 1 | Per-cell init term |
| preload_en | input | 1 | Test preload strobe |
| preload_val | input | 1 | Test preload value |
| observe_en | input | 1 | Test observe: drive stored bit on pin |
| oe_term | input | 1 | Output-enable product term |
| pin_out | output | 1 | Pin-bound data |
| pin_oe | output | 1 | Pin drive enable |
| fb_out | output | 1 | Internal feedback |

## Verification
A wrong stored bit reaches `fb_out` in the cycle after the edge that wrote it, so the error is visible before the next active clock. Observe mode exposes the raw stored bit even when the output enable is low. A corrupted configuration word shows up at the pins as a wrong inversion or mode as soon as it is captured. A corrupted edge history shows up at the next pulse of the selected clock, as a missed or duplicated update.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        OM_COMB  = 2'd0,
        OM_REG   = 2'd1,
        OM_LATCH = 2'd2,
        OM_REG2  = 2'd3
    } omode_e;

    typedef enum logic [1:0] {
        RT_D  = 2'd0,
        RT_T  = 2'd1,
        RT_JK = 2'd2,
        RT_SR = 2'd3
    } rtype_e;

    // Low ten configuration bits, MSB first
    typedef struct packed {
        logic   cell_preset;
        logic   init_swap;
        logic   pt_fall;
        logic   use_pt;
        logic   amode;
        rtype_e rtype;
        logic   pol_inv;
        omode_e omode;
    } mc_flags_t;

    localparam int FLAG_W = $bits(mc_flags_t);

endpackage

// File: rtl/mc_clk_src.sv
module mc_clk_src #(
    parameter int NCLK = 4,
    parameter int CSW  = 2
) (
    input  logic [NCLK-1:0] blk_clk,
    input  logic            pt_clk,
    input  logic [CSW-1:0]  csel,
    input  logic            take_pt,
    input  logic            pt_fall,
    input  logic            src_prev,
    output logic            src_now,
    output logic            edge_o
);
    logic blk_lvl;

    generate
        if (NCLK == 1) begin : g_one
            assign blk_lvl = blk_clk[0];
        end else begin : g_many
            assign blk_lvl = blk_clk[csel];
        end
    endgenerate

    // Active level normalised to 1 so one rising detector covers both edges
    assign src_now = take_pt ? (pt_clk ^ pt_fall) : blk_lvl;
    assign edge_o  = src_now & ~src_prev;
endmodule

// File: rtl/mc_init.sv
module mc_init (
    input  logic amode,
    input  logic swap,
    input  logic cell_preset,
    input  logic blk_a,
    input  logic blk_b,
    input  logic cell_term,
    output logic set_o,
    output logic clr_o
);
    always_comb begin
        if (amode) begin
            set_o = cell_term & cell_preset;
            clr_o = cell_term & ~cell_preset;
        end else begin
            set_o = swap ? blk_b : blk_a;
            clr_o = swap ? blk_a : blk_b;
        end
    end
endmodule

// File: rtl/mc_next.sv
module mc_next
    import mc_pkg::*;
(
    input  rtype_e rtype,
    input  logic   q,
    input  logic   a,
    input  logic   b,
    output logic   d
);
    logic tgl;

    always_comb begin
        unique case (rtype)
            RT_D:    tgl = a ^ q;
            RT_T:    tgl = a;
            RT_JK:   tgl = (a & ~q) | (b & q);
            default: tgl = (a & ~b & ~q) | (b & q);
        endcase
    end

    assign d = q ^ tgl;
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import mc_pkg::*;
#(
    parameter  int NCLK  = 4,
    localparam int CSW   = (NCLK > 1) ? $clog2(NCLK) : 1,
    localparam int CFG_W = FLAG_W + CSW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             sop_a,
    input  logic             sop_b,
    input  logic [NCLK-1:0]  blk_clk,
    input  logic             pt_clk,
    input  logic             blk_init_a,
    input  logic             blk_init_b,
    input  logic             cell_init,
    input  logic             preload_en,
    input  logic             preload_val,
    input  logic             observe_en,
    input  logic             oe_term,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             fb_out
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             store;
        logic             src;
    } st_t;

    st_t       s_d, s_q;
    mc_flags_t flg;
    logic [CSW-1:0] csel;
    logic src_now, edge_w, set_w, clr_w, d_reg, out_val;
    logic [1:0] omode_w;
    logic [CFG_W-1:0] cfg_q;
    logic store_q;

    assign flg     = mc_flags_t'(s_q.cfg[FLAG_W-1:0]);
    assign csel    = s_q.cfg[FLAG_W +: CSW];
    assign omode_w = flg.omode;
    assign cfg_q   = s_q.cfg;
    assign store_q = s_q.store;

    mc_clk_src #(.NCLK(NCLK), .CSW(CSW)) u_src (
        .blk_clk (blk_clk),
        .pt_clk  (pt_clk),
        .csel    (csel),
        .take_pt (flg.amode & flg.use_pt),
        .pt_fall (flg.pt_fall),
        .src_prev(s_q.src),
        .src_now (src_now),
        .edge_o  (edge_w)
    );

    mc_init u_init (
        .amode      (flg.amode),
        .swap       (flg.init_swap),
        .cell_preset(flg.cell_preset),
        .blk_a      (blk_init_a),
        .blk_b      (blk_init_b),
        .cell_term  (cell_init),
        .set_o      (set_w),
        .clr_o      (clr_w)
    );

    mc_next u_next (
        .rtype(flg.rtype),
        .q    (s_q.store),
        .a    (sop_a),
        .b    (sop_b),
        .d    (d_reg)
    );

    always_comb begin
        s_d     = s_q;
        s_d.src = src_now;
        if (cfg_we) s_d.cfg = cfg_in;

        if (clr_w)           s_d.store = 1'b0;
        else if (set_w)      s_d.store = 1'b1;
        else if (preload_en) s_d.store = preload_val;
        else begin
            unique case (flg.omode)
                OM_COMB:  s_d.store = s_q.store;
                OM_LATCH: s_d.store = src_now ? sop_a : s_q.store;
                default:  s_d.store = edge_w ? d_reg : s_q.store;
            endcase
        end

        out_val = (flg.omode == OM_COMB) ? sop_a : s_q.store;
        fb_out  = out_val;
        pin_out = observe_en ? s_q.store : (out_val ^ flg.pol_inv);
        pin_oe  = observe_en | oe_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
    parameter int CFG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_q,
    input logic             store_q,
    input logic             edge_w,
    input logic             set_w,
    input logic             clr_w,
    input logic [1:0]       omode_w,
    input logic             preload_en,
    input logic             preload_val,
    input logic             observe_en,
    input logic             pin_oe,
    input logic             pin_out,
    input logic             fb_out,
    input logic             sop_a
);
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && clr_w) |=> !store_q); // R7

    AST_SET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w && !clr_w) |=> store_q); // R5

    AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !set_w && !clr_w) |=> (store_q == $past(preload_val))); // R9

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((omode_w == 2'd1) && !edge_w && !set_w && !clr_w && !preload_en)
        |=> $stable(store_q)); // R3

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R13

    AST_OBSERVE: assert property (@(posedge clk) disable iff (!rst_n)
        observe_en |-> (pin_oe && (pin_out == store_q))); // R10

    AST_FB_COMB: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_w == 2'd0) |-> (fb_out == sop_a)); // R11
endmodule

bind pld_macrocell mc_checker #(.CFG_W(CFG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_q      (cfg_q),
    .store_q    (store_q),
    .edge_w     (edge_w),
    .set_w      (set_w),
    .clr_w      (clr_w),
    .omode_w    (omode_w),
    .preload_en (preload_en),
    .preload_val(preload_val),
    .observe_en (observe_en),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .fb_out     (fb_out),
    .sop_a      (sop_a)
);

// File: tb/tb_pld_macrocell.sv
`timescale 1ns/1ps
module tb_pld_macrocell;
    localparam int NCLK  = 4;
    localparam int CFG_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CFG_W-1:0] cfg_in = '0;
    logic sop_a = 1'b0, sop_b = 1'b0;
    logic [NCLK-1:0] blk_clk = '0;
    logic pt_clk = 1'b0, blk_init_a = 1'b0, blk_init_b = 1'b0, cell_init = 1'b0;
    logic preload_en = 1'b0, preload_val = 1'b0, observe_en = 1'b0, oe_term = 1'b0;
    logic pin_out, pin_oe, fb_out;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pld_macrocell #(.NCLK(NCLK)) dut (.*);

    // {rtype[1:0], a, b, expected stored bit}
    localparam logic [4:0] VEC [14] = '{
        {2'd0,1'b1,1'b0,1'b1}, {2'd0,1'b0,1'b0,1'b0},
        {2'd1,1'b1,1'b0,1'b1}, {2'd1,1'b1,1'b0,1'b0}, {2'd1,1'b0,1'b0,1'b0},
        {2'd2,1'b1,1'b0,1'b1}, {2'd2,1'b1,1'b1,1'b0}, {2'd2,1'b0,1'b1,1'b0},
        {2'd2,1'b1,1'b1,1'b1}, {2'd2,1'b0,1'b0,1'b1},
        {2'd3,1'b0,1'b1,1'b0}, {2'd3,1'b1,1'b0,1'b1}, {2'd3,1'b1,1'b1,1'b0},
        {2'd3,1'b0,1'b0,1'b0}
    };

    function automatic logic [CFG_W-1:0] mk(input logic [1:0] om, input logic pol,
        input logic [1:0] rt, input logic am, input logic upt, input logic pfall,
        input logic swp, input logic cpre, input logic [1:0] cs);
        return {cs, cpre, swp, pfall, upt, am, rt, pol, om};
    endfunction

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic setcfg(input logic [CFG_W-1:0] v);
        cfg_in = v; cfg_we = 1'b1; cyc(); cfg_we = 1'b0;
    endtask

    task automatic pload(input logic v);
        preload_en = 1'b1; preload_val = v; cyc(); preload_en = 1'b0;
    endtask

    task automatic pulse(input int k);
        blk_clk[k] = 1'b1; cyc(); blk_clk[k] = 1'b0; cyc();
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk("R8 reset pin", pin_out, 1'b0);
        chk("R8 reset fb", fb_out, 1'b0);
        chk("R10 reset oe", pin_oe, 1'b0);

        // Registered, inverted: cleared bit shows as 1 on the pin
        setcfg(mk(2'd1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        chk("R8 polarity after reset", pin_out, 1'b1);
        chk("R8 stored zero", fb_out, 1'b0);

        // R13: config not captured without enable
        cfg_in = mk(2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0);
        sop_a = 1'b1; cyc(); sop_a = 1'b0;
        chk("R13 cfg held", pin_out, 1'b1);

        // R2 flop types from the vector table
        setcfg(mk(2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        pload(1'b0);
        for (int i = 0; i < 14; i++) begin
            setcfg(mk(2'd1,1'b0,VEC[i][4:3],1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
            sop_a = VEC[i][2]; sop_b = VEC[i][1];
            pulse(0);
            chk($sformatf("R2 type vector %0d", i), fb_out, VEC[i][0]);
        end
        sop_a = 1'b0; sop_b = 1'b0;

        // R3 clock select
        setcfg(mk(2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd2));
        pload(1'b0);
        sop_a = 1'b1;
        pulse(0); pulse(1); pulse(3);
        chk("R3 other clocks ignored", fb_out, 1'b0);
        pulse(2);
        chk("R3 selected clock", fb_out, 1'b1);
        chk("R1 registered pin", pin_out, 1'b1);

        // R4 product-term clock, falling edge
        setcfg(mk(2'd1,1'b0,2'd0,1'b1,1'b1,1'b1,1'b0,1'b0,2'd0));
        pload(1'b0);
        sop_a = 1'b1;
        pt_clk = 1'b1; cyc();
        chk("R4 rising ignored", fb_out, 1'b0);
        pulse(0);
        chk("R4 block clock ignored", fb_out, 1'b0);
        pt_clk = 1'b0; cyc();
        chk("R4 falling edge", fb_out, 1'b1);
        sop_a = 1'b0;

        // R5 block init with swap
        setcfg(mk(2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        pload(1'b0);
        blk_init_a = 1'b1; cyc(); blk_init_a = 1'b0;
        chk("R5 A presets", fb_out, 1'b1);
        blk_init_b = 1'b1; cyc(); blk_init_b = 1'b0;
        chk("R5 B clears", fb_out, 1'b0);
        setcfg(mk(2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0));
        blk_init_b = 1'b1; cyc(); blk_init_b = 1'b0;
        chk("R5 swapped B presets", fb_out, 1'b1);
        blk_init_a = 1'b1; cyc(); blk_init_a = 1'b0;
        chk("R5 swapped A clears", fb_out, 1'b0);

        // R7 priorities
        pload(1'b1);
        blk_init_a = 1'b1; blk_init_b = 1'b1; cyc();
        blk_init_a = 1'b0; blk_init_b = 1'b0;
        chk("R7 clear beats preset", fb_out, 1'b0);
        preload_en = 1'b1; preload_val = 1'b1; blk_init_a = 1'b1; cyc();
        preload_en = 1'b0; blk_init_a = 1'b0;
        chk("R7 init beats preload", fb_out, 1'b0);

        // R6 per-cell init in asynchronous mode
        setcfg(mk(2'd1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b1,2'd0));
        pload(1'b0);
        blk_init_a = 1'b1; cyc(); blk_init_a = 1'b0;
        chk("R6 block A ignored", fb_out, 1'b0);
        cell_init = 1'b1; cyc(); cell_init = 1'b0;
        chk("R6 cell preset", fb_out, 1'b1);
        blk_init_b = 1'b1; cyc(); blk_init_b = 1'b0;
        chk("R6 block B ignored", fb_out, 1'b1);
        setcfg(mk(2'd1,1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd0));
        cell_init = 1'b1; cyc(); cell_init = 1'b0;
        chk("R6 cell reset", fb_out, 1'b0);

        // R12 latch
        setcfg(mk(2'd2,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        pload(1'b0);
        sop_a = 1'b1; blk_clk[0] = 1'b1; cyc();
        chk("R12 transparent", fb_out, 1'b1);
        sop_a = 1'b0; cyc();
        chk("R12 follows", fb_out, 1'b0);
        blk_clk[0] = 1'b0; sop_a = 1'b1; cyc(); cyc();
        chk("R12 holds", fb_out, 1'b0);

        // R1 and R11 combinatorial
        setcfg(mk(2'd0,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        sop_a = 1'b1; #1;
        chk("R1 comb inverted", pin_out, 1'b0);
        chk("R11 feedback comb", fb_out, 1'b1);
        chk("R11 oe low", pin_oe, 1'b0);
        sop_a = 1'b0; #1;
        chk("R1 comb inverted low", pin_out, 1'b1);
        @(negedge clk);

        // R9 preload and R10 observe
        setcfg(mk(2'd1,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0));
        pload(1'b1);
        chk("R9 preload", fb_out, 1'b1);
        chk("R1 inverted registered", pin_out, 1'b0);
        observe_en = 1'b1; #1;
        chk("R10 observe oe", pin_oe, 1'b1);
        chk("R10 observe raw", pin_out, 1'b1);
        @(negedge clk); observe_en = 1'b0; oe_term = 1'b1; #1;
        chk("R10 oe term", pin_oe, 1'b1);
        oe_term = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule